// File: doc/BRIEF.md
# Register Mailbox Message Requester

This block is a bus master that hands one command at a time to a power-management controller through three memory-mapped registers: a message register, an argument register and a response register. A client offers a message ID, a 32-bit parameter and a flag that asks for a read-back value, using a valid/ready handshake. The block then runs the whole exchange over a simple register read/write bus and answers with a one-cycle completion pulse.

Before it issues a command, the block polls the response register until it reads non-zero. This shows that the previous command has finished. If the retry budget runs out, it goes ahead anyway. It then clears the response register, writes the argument and writes the message ID. Writing the message ID starts the transaction. Next it polls the response register again, and the first non-zero value it reads is the result code. A code of 0x01 means success. In that case, if the client asked for it, the block reads the argument register back and returns its value. Any other non-zero code is reported as a rejected command. If every poll reads zero, the block reports a timeout.

Between unsuccessful polls the block waits a programmable number of microseconds. The microsecond is measured with a tick counter derived from the clock-frequency parameter. The poll budget is also programmable. Both settings are captured when a request is accepted.

Top module: `mbox_requester`

## Requirements
- R1: After reset, req_ready is 1 and done, bus_req, rsp_status, rsp_code and rsp_param are all 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the done pulse, and any change on the request inputs in that window has no effect on the command that is sent.
- R3: Before writing, the block reads the response register (address 0x16274) until a read returns non-zero. It makes at most cfg_retries+1 such reads, and it carries on with the writes even if every one of them read zero.
- R4: A command makes exactly three writes, in this order: 0 to the response register (0x16274), then the parameter to the argument register (0x16273), then the message ID to the message register (0x1628A).
- R5: After the message write, the block polls the response register and stops at the first non-zero read. That value is the result code.
- R6: Two consecutive response polls of one phase are at least cfg_delay_us×(CLK_FREQ_HZ/1e6)+2 and at most that value +10 clock cycles apart.
- R7: When the result code is 0x01 and req_want_out was 1, the block makes one read of the argument register. It then reports rsp_status=0 (OK), rsp_code=0x01 and rsp_param equal to the value read.
- R8: When the result code is 0x01 and req_want_out was 0, the block does not read the argument register, and rsp_param is 0.
- R9: When the result code is non-zero and not 0x01, the block reports rsp_status=1 (rejected) with rsp_code equal to that code and rsp_param 0, and it does not read the argument register.
- R10: When cfg_retries+1 response polls after the message write all read zero, the block reports rsp_status=2 (timeout) with rsp_code 0 and rsp_param 0.
- R11: done is a single-cycle pulse. rsp_status, rsp_code and rsp_param change only with done and hold their values until the next done.
- R12: Once bus_req is raised it stays 1, and bus_we, bus_addr and bus_wdata stay stable, until bus_ack is sampled as 1. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delay_us | input | DLY_W | Wait between unsuccessful polls, in microseconds |
| cfg_retries | input | RTY_W | Extra polls allowed after the first, per polling phase |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_msg_id | input | DATA_W | Message ID to write |
| req_param | input | DATA_W | Argument to write |
| req_want_out | input | 1 | Read the argument register back on success |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 OK, 1 rejected, 2 timeout |
| rsp_code | output | DATA_W | Result code read from the response register |
| rsp_param | output | DATA_W | Read-back value, 0 when none |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete, one-cycle pulse |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
Every result of a command is due in the single cycle in which done is high. That cycle comes some number of cycles after acceptance, and the number depends on the poll count and the wait. The bench therefore does not count toward it. It steps on falling edges until it sees done and samples all three result outputs in that same cycle. It looks again three cycles later to confirm they have held. The bench's bus responder acknowledges one cycle after it sees a request, so the spacing of polls is measured between acknowledge cycles. That spacing is compared against the programmed wait plus a window of 2 to 10 cycles of handshake overhead. Access counts and the write order are logged at the bus, so that skipped reads and wrong order show up at the ports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    MB_ST_OK      = 2'd0,
    MB_ST_REJECT  = 2'd1,
    MB_ST_TIMEOUT = 2'd2
  } mb_status_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_PRE_RD,
    SQ_PRE_GAP,
    SQ_CLR_WR,
    SQ_ARG_WR,
    SQ_MSG_WR,
    SQ_POST_RD,
    SQ_POST_GAP,
    SQ_BACK_RD
  } seq_state_e;

endpackage

// File: rtl/mbox_bus_port.sv
module mbox_bus_port #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (bus_req_o) begin
        if (bus_ack_i) begin
          bus_req_o <= 1'b0;
          done_o    <= 1'b1;
          rdata_o   <= bus_rdata_i;
        end
      end else if (start_i) begin
        bus_req_o   <= 1'b1;
        bus_we_o    <= we_i;
        bus_addr_o  <= addr_i;
        bus_wdata_o <= wdata_i;
      end
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !bus_req_o);

endmodule

// File: rtl/mbox_us_timer.sv
module mbox_us_timer #(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int DLY_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_us_i,
  output logic             done_o
);

  localparam int TPU = (CLK_FREQ_HZ / 1_000_000 > 0) ? CLK_FREQ_HZ / 1_000_000 : 1;
  localparam int TW  = (TPU > 1) ? $clog2(TPU) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TPU - 1);

  logic             run;
  logic [TW-1:0]    tick;
  logic [DLY_W-1:0] us_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      tick    <= '0;
      us_left <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        if (delay_us_i == '0) begin
          done_o <= 1'b1;
        end else begin
          run     <= 1'b1;
          us_left <= delay_us_i;
          tick    <= TLAST;
        end
      end else if (run) begin
        if (tick == '0) begin
          tick    <= TLAST;
          us_left <= us_left - DLY_W'(1);
          if (us_left == DLY_W'(1)) begin
            run    <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          tick <= tick - TW'(1);
        end
      end
    end
  end

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !run);

endmodule

// File: rtl/mbox_requester.sv
module mbox_requester
  import mbox_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 32,
  parameter int          DLY_W       = 16,
  parameter int          RTY_W       = 18,
  parameter int          CLK_FREQ_HZ = 100_000_000,
  parameter logic [19:0] MSG_ADDR    = 20'h1628A,
  parameter logic [19:0] ARG_ADDR    = 20'h16273,
  parameter logic [19:0] RESP_ADDR   = 20'h16274,
  parameter int          OK_CODE     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  cfg_delay_us,
  input  logic [RTY_W-1:0]  cfg_retries,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_msg_id,
  input  logic [DATA_W-1:0] req_param,
  input  logic              req_want_out,
  output logic              done,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_code,
  output logic [DATA_W-1:0] rsp_param,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(MSG_ADDR);
  localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(ARG_ADDR);
  localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(RESP_ADDR);
  localparam logic [DATA_W-1:0] C_OK   = DATA_W'(OK_CODE);

  seq_state_e        state;
  logic              armed;
  logic [RTY_W-1:0]  tries_left;
  logic [DATA_W-1:0] id_q, par_q, code_hold;
  logic              want_q;
  logic [DLY_W-1:0]  dly_q;
  logic [RTY_W-1:0]  rty_q;

  logic              bp_start, bp_we, bp_done;
  logic [ADDR_W-1:0] bp_addr;
  logic [DATA_W-1:0] bp_wdata, bp_rdata;
  logic              tm_start, tm_done;
  logic              in_access, in_gap;

  always_comb begin
    in_access = 1'b1;
    bp_we     = 1'b0;
    bp_addr   = A_RESP;
    bp_wdata  = '0;
    case (state)
      SQ_PRE_RD, SQ_POST_RD: ;
      SQ_CLR_WR: bp_we = 1'b1;
      SQ_ARG_WR: begin bp_we = 1'b1; bp_addr = A_ARG; bp_wdata = par_q; end
      SQ_MSG_WR: begin bp_we = 1'b1; bp_addr = A_MSG; bp_wdata = id_q; end
      SQ_BACK_RD: bp_addr = A_ARG;
      default:   in_access = 1'b0;
    endcase
    in_gap   = (state == SQ_PRE_GAP) || (state == SQ_POST_GAP);
    bp_start = in_access && !armed;
    tm_start = in_gap && !armed;
  end

  assign req_ready = (state == SQ_IDLE);

  mbox_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .start_i     (bp_start),
    .we_i        (bp_we),
    .addr_i      (bp_addr),
    .wdata_i     (bp_wdata),
    .done_o      (bp_done),
    .rdata_o     (bp_rdata),
    .bus_req_o   (bus_req),
    .bus_we_o    (bus_we),
    .bus_addr_o  (bus_addr),
    .bus_wdata_o (bus_wdata),
    .bus_ack_i   (bus_ack),
    .bus_rdata_i (bus_rdata)
  );

  mbox_us_timer #(.CLK_FREQ_HZ(CLK_FREQ_HZ), .DLY_W(DLY_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start_i    (tm_start),
    .delay_us_i (dly_q),
    .done_o     (tm_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      armed      <= 1'b0;
      tries_left <= '0;
      id_q       <= '0;
      par_q      <= '0;
      want_q     <= 1'b0;
      dly_q      <= '0;
      rty_q      <= '0;
      code_hold  <= '0;
      done       <= 1'b0;
      rsp_status <= MB_ST_OK;
      rsp_code   <= '0;
      rsp_param  <= '0;
    end else begin
      done <= 1'b0;
      if (bp_start || tm_start) armed <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            id_q       <= req_msg_id;
            par_q      <= req_param;
            want_q     <= req_want_out;
            dly_q      <= cfg_delay_us;
            rty_q      <= cfg_retries;
            tries_left <= cfg_retries;
            armed      <= 1'b0;
            state      <= SQ_PRE_RD;
          end
        end
        SQ_PRE_RD: begin
          if (bp_done) begin
            armed <= 1'b0;
            if (bp_rdata != '0 || tries_left == '0) begin
              state <= SQ_CLR_WR;
            end else begin
              tries_left <= tries_left - RTY_W'(1);
              state      <= SQ_PRE_GAP;
            end
          end
        end
        SQ_PRE_GAP: begin
          if (tm_done) begin
            armed <= 1'b0;
            state <= SQ_PRE_RD;
          end
        end
        SQ_CLR_WR: begin
          if (bp_done) begin
            armed <= 1'b0;
            state <= SQ_ARG_WR;
          end
        end
        SQ_ARG_WR: begin
          if (bp_done) begin
            armed <= 1'b0;
            state <= SQ_MSG_WR;
          end
        end
        SQ_MSG_WR: begin
          if (bp_done) begin
            armed      <= 1'b0;
            tries_left <= rty_q;
            state      <= SQ_POST_RD;
          end
        end
        SQ_POST_RD: begin
          if (bp_done) begin
            armed <= 1'b0;
            if (bp_rdata != '0) begin
              code_hold <= bp_rdata;
              if (bp_rdata == C_OK && want_q) begin
                state <= SQ_BACK_RD;
              end else begin
                done       <= 1'b1;
                rsp_status <= (bp_rdata == C_OK) ? MB_ST_OK : MB_ST_REJECT;
                rsp_code   <= bp_rdata;
                rsp_param  <= '0;
                state      <= SQ_IDLE;
              end
            end else if (tries_left == '0) begin
              done       <= 1'b1;
              rsp_status <= MB_ST_TIMEOUT;
              rsp_code   <= '0;
              rsp_param  <= '0;
              state      <= SQ_IDLE;
            end else begin
              tries_left <= tries_left - RTY_W'(1);
              state      <= SQ_POST_GAP;
            end
          end
        end
        SQ_POST_GAP: begin
          if (tm_done) begin
            armed <= 1'b0;
            state <= SQ_POST_RD;
          end
        end
        SQ_BACK_RD: begin
          if (bp_done) begin
            armed      <= 1'b0;
            done       <= 1'b1;
            rsp_status <= MB_ST_OK;
            rsp_code   <= code_hold;
            rsp_param  <= bp_rdata;
            state      <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rsp_code) || !$stable(rsp_param) || !$stable(rsp_status)) |-> done);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == A_RESP) |-> bus_wdata == '0);

  // R10
  timeout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_status == MB_ST_TIMEOUT) |-> (rsp_code == '0 && rsp_param == '0));

  // R9
  param_only_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_status != MB_ST_OK) |-> rsp_param == '0);

  // R7
  ok_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_status == MB_ST_OK) |-> rsp_code == C_OK);

endmodule

// File: tb/mbox_requester_tb_top.sv
`timescale 1ns/1ps
module mbox_requester_tb_top;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int DLY_W  = 16;
  localparam int RTY_W  = 18;
  localparam int TPU    = 100;
  localparam logic [ADDR_W-1:0] A_MSG  = 20'h1628A;
  localparam logic [ADDR_W-1:0] A_ARG  = 20'h16273;
  localparam logic [ADDR_W-1:0] A_RESP = 20'h16274;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [DLY_W-1:0]  cfg_delay_us = '0;
  logic [RTY_W-1:0]  cfg_retries = '0;
  logic              req_valid = 1'b0, req_ready, req_want_out = 1'b0;
  logic [DATA_W-1:0] req_msg_id = '0, req_param = '0;
  logic              done;
  logic [1:0]        rsp_status;
  logic [DATA_W-1:0] rsp_code, rsp_param;
  logic              bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;

  mbox_requester #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .RTY_W(RTY_W),
    .CLK_FREQ_HZ(TPU * 1_000_000)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_delay_us(cfg_delay_us), .cfg_retries(cfg_retries),
    .req_valid(req_valid), .req_ready(req_ready), .req_msg_id(req_msg_id),
    .req_param(req_param), .req_want_out(req_want_out), .done(done),
    .rsp_status(rsp_status), .rsp_code(rsp_code), .rsp_param(rsp_param),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // register responder model
  logic [DATA_W-1:0] resp_reg, arg_reg, fw_code, fw_arg;
  int fw_post_zeros, zeros_left;
  int n_pre, n_post, n_argrd, n_wr;
  bit msg_written, prev_resp_rd;
  longint cyc = 0, last_rd_cyc, gap_min, gap_max;
  logic [ADDR_W-1:0] wr_addr [0:7];
  logic [DATA_W-1:0] wr_data [0:7];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        if (n_wr < 8) begin
          wr_addr[n_wr] = bus_addr;
          wr_data[n_wr] = bus_wdata;
        end
        n_wr = n_wr + 1;
        prev_resp_rd = 1'b0;
        if (bus_addr == A_RESP) resp_reg = bus_wdata;
        if (bus_addr == A_ARG)  arg_reg = bus_wdata;
        if (bus_addr == A_MSG) begin
          resp_reg    = fw_code;
          arg_reg     = fw_arg;
          zeros_left  = fw_post_zeros;
          msg_written = 1'b1;
        end
      end else if (bus_addr == A_RESP) begin
        if (zeros_left > 0) begin
          bus_rdata  <= '0;
          zeros_left = zeros_left - 1;
        end else begin
          bus_rdata <= resp_reg;
        end
        if (msg_written) n_post = n_post + 1; else n_pre = n_pre + 1;
        if (prev_resp_rd) begin
          if (cyc - last_rd_cyc < gap_min) gap_min = cyc - last_rd_cyc;
          if (cyc - last_rd_cyc > gap_max) gap_max = cyc - last_rd_cyc;
        end
        prev_resp_rd = 1'b1;
        last_rd_cyc  = cyc;
      end else begin
        bus_rdata    <= arg_reg;
        n_argrd      = n_argrd + 1;
        prev_resp_rd = 1'b0;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic run_case(input int pre_z, input int post_z, input logic [DATA_W-1:0] code,
                          input bit want, input int dly, input int rty, input int k);
    logic [DATA_W-1:0] id, par, arg;
    logic [1:0] st_q;
    logic [DATA_W-1:0] code_q, out_q;
    int exp_pre, exp_post, exp_arg, wait_cyc;
    bit tmo, got;
    logic [1:0] exp_st;
    logic [DATA_W-1:0] exp_code, exp_out;
    id  = 32'h0000_0100 + k;
    par = 32'hA500_0000 ^ k;
    arg = par + 32'd1;
    @(negedge clk);
    resp_reg = 32'h1; arg_reg = '0; fw_code = code; fw_arg = arg;
    fw_post_zeros = post_z; zeros_left = pre_z;
    n_pre = 0; n_post = 0; n_argrd = 0; n_wr = 0;
    msg_written = 1'b0; prev_resp_rd = 1'b0;
    gap_min = 64'd1_000_000; gap_max = 0;
    cfg_delay_us = DLY_W'(dly); cfg_retries = RTY_W'(rty);
    req_msg_id = id; req_param = par; req_want_out = want; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    // R2: junk on the request inputs while busy must not be used
    req_msg_id = ~id; req_param = ~par; req_want_out = ~want;
    wait_cyc = 0; got = 1'b0;
    while (!got && wait_cyc < 5000) begin
      @(negedge clk);
      wait_cyc++;
      if (done) got = 1'b1;
    end
    req_valid = 1'b0;
    chk(got, "R11", "done seen (watchdog)", wait_cyc, 0);
    st_q = rsp_status; code_q = rsp_code; out_q = rsp_param;

    exp_pre  = (pre_z > rty) ? rty + 1 : pre_z + 1;
    tmo      = (code == '0) || (post_z > rty);
    exp_post = tmo ? rty + 1 : post_z + 1;
    exp_st   = tmo ? 2'd2 : ((code == 32'h1) ? 2'd0 : 2'd1);
    exp_code = tmo ? '0 : code;
    exp_out  = (!tmo && code == 32'h1 && want) ? arg : '0;
    exp_arg  = (!tmo && code == 32'h1 && want) ? 1 : 0;

    chk(n_pre == exp_pre, "R3", "pre-poll reads", n_pre, exp_pre);
    chk(n_wr == 3 && wr_addr[0] == A_RESP && wr_data[0] == '0 &&
        wr_addr[1] == A_ARG && wr_data[1] == par &&
        wr_addr[2] == A_MSG && wr_data[2] == id, "R4", "write order/data (count)", n_wr, 3);
    chk(n_post == exp_post, tmo ? "R10" : "R5", "post-poll reads", n_post, exp_post);
    chk(st_q == exp_st, tmo ? "R10" : (code == 32'h1 ? "R7" : "R9"), "status", st_q, exp_st);
    chk(code_q == exp_code, "R5", "result code", code_q, exp_code);
    chk(out_q == exp_out, want ? "R7" : "R8", "read-back value", out_q, exp_out);
    chk(n_argrd == exp_arg, want ? "R7" : "R8", "argument reads", n_argrd, exp_arg);
    if (exp_pre > 1 || exp_post > 1) begin
      chk(gap_min >= dly * TPU + 2, "R6", "min poll gap", gap_min, dly * TPU + 2);
      chk(gap_max <= dly * TPU + 10, "R6", "max poll gap", gap_max, dly * TPU + 10);
    end
    repeat (3) @(negedge clk);
    chk(!done && rsp_status == st_q && rsp_code == code_q && rsp_param == out_q,
        "R11", "outputs held after done", done, 0);
    chk(req_ready && !bus_req, "R2", "idle again", req_ready, 1);
  endtask

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(!done && !bus_req, "R1", "done/bus_req after reset", done, 0);
    chk(rsp_status == 2'd0 && rsp_code == '0 && rsp_param == '0, "R1",
        "results after reset", rsp_code, 0);
    chk(bus_ack == 1'b0, "R12", "no access before request", bus_req, 0);
    k = 0;
    foreach (int_pre[i]) ;
    for (int ip = 0; ip < 3; ip++) begin
      for (int iq = 0; iq < 3; iq++) begin
        for (int ic = 0; ic < 2; ic++) begin
          for (int iw = 0; iw < 2; iw++) begin
            run_case((ip == 2) ? 4 : ip, iq * 2, (ic == 0) ? 32'h1 : 32'h5,
                     iw[0], 1, 3, k);
            k++;
          end
        end
      end
    end
    // R10: controller never answers
    run_case(0, 0, 32'h0, 1'b1, 2, 3, k++);
    // R6: longer wait with several pre-polls
    run_case(2, 1, 32'h1, 1'b1, 2, 3, k++);
    // R3/R10: zero retry budget
    run_case(1, 1, 32'h1, 1'b0, 1, 0, k++);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int int_pre [1];

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule